// File: doc/BRIEF.md
# DRAM Refresh and Wake-up Scheduler

This block keeps an asynchronous DRAM alive. Out of reset it keeps the memory untouched for a start-up pause. It then runs a short burst of wake-up refresh cycles and raises `init_done`. From then on it asks for one refresh every refresh interval, so that the whole row space is refreshed within the retention period.

Refresh cycles are driven straight onto the row and column strobes. The block raises `ref_req` and starts a cycle only once the access sequencer answers with `ref_gnt`. It lowers `ref_req` for at least one clock when the cycle is over, which is how the sequencer learns that it may take the strobes back. Intervals that expire while the grant is withheld are queued in a bounded count. A refresh that begins with more than one interval outstanding counts as late. If the queue overflows, the retention deadline is treated as lost: `init_done` drops and the wake-up burst runs again.

By default a refresh cycle lowers the column strobe before the row strobe, so the memory's own row counter selects the row. A parameter selects row-strobe-only refresh instead. In that mode the block supplies the row address from its own wrapping counter.

Top module: `dref_sched`

## Requirements
- R1: While `rst` is high and on the first clock after it, `ras_n` and `cas_n` are 1, `ref_req` is 0, `init_done` is 0 and `late_cnt` is 0.
- R2: `ref_req` stays 0 for at least PAUSE_CYC clocks after `rst` falls, and rises within a few clocks after that.
- R3: After the pause, exactly WAKE_CYCLES (default 8) refresh cycles complete before `init_done` rises. `init_done` is not raised before the last of them.
- R4: In the default mode, `cas_n` is 0 for exactly SETUP_CYC clocks with `ras_n` still 1 before `ras_n` falls, and `cas_n` stays 0 while `ras_n` is 0.
- R5: Each refresh holds `ras_n` at 0 for exactly RAS_LOW_CYC clocks. `ras_n` then stays at 1 for exactly PRECHG_CYC clocks before `ref_req` drops, and `ref_req` stays 0 for at least one clock between cycles.
- R6: No refresh cycle starts without `ref_gnt`. While the grant is withheld, `ras_n` and `cas_n` stay 1 and `ref_req` stays 1.
- R7: With the grant given promptly, periodic refreshes occur once per INTERVAL_CYC clocks on average, and `late_cnt` does not change.
- R8: A periodic refresh that starts while two or more intervals are outstanding adds one to `late_cnt`. `late_cnt` saturates at its maximum value.
- R9: When an interval expires while MAX_PEND refreshes are already outstanding, `init_done` falls to 0. Outstanding work is discarded and a full WAKE_CYCLES burst runs before `init_done` rises again.
- R10: With RAS_ONLY=1, `cas_n` stays 1 at all times. `row_addr` is valid from before `ras_n` falls until after it rises, and it advances by one after each refresh, wrapping from ROWS-1 (1023 by default) to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Sequencer hands the strobes to the block |
| ref_req | output | 1 | Block wants, or is using, the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| row_addr | output | ROW_W (10) | Refresh row for row-strobe-only mode, 0 otherwise |
| init_done | output | 1 | Pause and wake-up burst complete, deadline held |
| late_cnt | output | LATE_W (8) | Saturating count of late refreshes |

## Verification
The grant is driven in four patterns, and each separates a different piece of behaviour.

- A prompt grant shows the start-up ordering and the steady cadence. It shows that the burst length is exact and that no lateness is counted.
- A grant withheld for two and a half intervals leaves two refreshes queued. This tells a correctly counted late service apart from an on-time one, and shows that the strobes stay idle while the grant is absent.
- A grant withheld past the queue limit has to drop `init_done` and start a fresh eight-cycle burst, which no shorter stall does.
- A second instance in row-only mode runs long enough to wrap its row counter past 1023.

// File: rtl/dref_pkg.sv
package dref_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACT,
    ST_PRE,
    ST_GAP
  } dref_state_e;
endpackage

// File: rtl/dref_ticker.sv
module dref_ticker #(
  parameter int PAUSE_CYC    = 25000,
  parameter int INTERVAL_CYC = 1953
) (
  input  logic clk,
  input  logic rst,
  output logic run,
  output logic pause_end,
  output logic tick
);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int IW = $clog2(INTERVAL_CYC + 1);

  logic [PW-1:0] pcnt;
  logic [IW-1:0] icnt;

  assign pause_end = !run && (pcnt == '0);
  assign tick      = run && (icnt == '0);

  // interval reloads on expiry, independent of when service happens
  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      pcnt <= PW'(PAUSE_CYC - 1);
      icnt <= '0;
    end else if (!run) begin
      if (pcnt == '0) begin
        run  <= 1'b1;
        icnt <= IW'(INTERVAL_CYC - 1);
      end else begin
        pcnt <= pcnt - 1'b1;
      end
    end else if (icnt == '0) begin
      icnt <= IW'(INTERVAL_CYC - 1);
    end else begin
      icnt <= icnt - 1'b1;
    end
  end
endmodule

// File: rtl/dref_budget.sv
module dref_budget #(
  parameter int WAKE_CYCLES = 8,
  parameter int MAX_PEND    = 4,
  parameter int LATE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pause_end,
  input  logic              tick,
  input  logic              start,
  input  logic              done,
  output logic              want,
  output logic              init_done,
  output logic [LATE_W-1:0] late_cnt
);
  localparam int PEND_W = $clog2(MAX_PEND + 1);
  localparam int WAKE_W = $clog2(WAKE_CYCLES + 1);

  logic [PEND_W-1:0] pending, pend_d;
  logic [WAKE_W-1:0] wake_left, wake_d;
  logic [LATE_W-1:0] late_d;
  logic              cur_wake, curw_d, init_d;

  assign want = (wake_left != '0) || (pending != '0);

  always_comb begin
    pend_d = pending;
    wake_d = wake_left;
    late_d = late_cnt;
    curw_d = cur_wake;
    init_d = init_done;
    if (start) begin
      if (wake_left != '0) begin
        wake_d = wake_left - 1'b1;
        curw_d = 1'b1;
      end else begin
        pend_d = pending - 1'b1;
        curw_d = 1'b0;
        if ((pending > 1) && (late_cnt != {LATE_W{1'b1}}))
          late_d = late_cnt + 1'b1;
      end
    end
    if (done && cur_wake && (wake_left == '0))
      init_d = 1'b1;
    if (tick) begin
      if (pend_d == PEND_W'(MAX_PEND)) begin
        pend_d = '0;
        wake_d = WAKE_W'(WAKE_CYCLES);
        init_d = 1'b0;
      end else begin
        pend_d = pend_d + 1'b1;
      end
    end
    if (pause_end)
      wake_d = WAKE_W'(WAKE_CYCLES);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= '0;
      wake_left <= '0;
      late_cnt  <= '0;
      cur_wake  <= 1'b0;
      init_done <= 1'b0;
    end else begin
      pending   <= pend_d;
      wake_left <= wake_d;
      late_cnt  <= late_d;
      cur_wake  <= curw_d;
      init_done <= init_d;
    end
  end

  AST_PEND_CAP: assert property (@(posedge clk) disable iff (rst)
    pending <= PEND_W'(MAX_PEND)); // R9
  AST_INIT_AFTER_BURST: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> (wake_left == '0)); // R3
  AST_LATE_MONO: assert property (@(posedge clk) disable iff (rst)
    late_cnt >= $past(late_cnt)); // R8
endmodule

// File: rtl/dref_strobe.sv
module dref_strobe
  import dref_pkg::*;
#(
  parameter int SETUP_CYC   = 2,
  parameter int RAS_LOW_CYC = 4,
  parameter int PRECHG_CYC  = 3,
  parameter int ROW_W       = 10,
  parameter bit RAS_ONLY    = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             want,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] row_addr,
  output logic             start,
  output logic             done
);
  localparam int MAX_AB = (SETUP_CYC > RAS_LOW_CYC) ? SETUP_CYC : RAS_LOW_CYC;
  localparam int MAX_C  = (MAX_AB > PRECHG_CYC) ? MAX_AB : PRECHG_CYC;
  localparam int CW     = $clog2(MAX_C + 1);

  dref_state_e   state, nxt;
  logic [CW-1:0] cnt;

  assign start = (state == ST_IDLE) && ref_req && ref_gnt;
  assign done  = (state == ST_PRE) && (cnt == '0);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (start)      nxt = ST_SETUP;
      ST_SETUP: if (cnt == '0)  nxt = ST_ACT;
      ST_ACT:   if (cnt == '0)  nxt = ST_PRE;
      ST_PRE:   if (cnt == '0)  nxt = ST_GAP;
      default:                  nxt = ST_IDLE;
    endcase
  end

  // strobes registered from the next state: aligned with state, glitch-free
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      ref_req <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != state) begin
        case (nxt)
          ST_SETUP: cnt <= CW'(SETUP_CYC - 1);
          ST_ACT:   cnt <= CW'(RAS_LOW_CYC - 1);
          ST_PRE:   cnt <= CW'(PRECHG_CYC - 1);
          default:  cnt <= '0;
        endcase
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
      ras_n   <= (nxt != ST_ACT);
      cas_n   <= RAS_ONLY ? 1'b1 : !((nxt == ST_SETUP) || (nxt == ST_ACT));
      ref_req <= (nxt == ST_IDLE) ? want : (nxt != ST_GAP);
    end
  end

  generate
    if (RAS_ONLY) begin : g_rowcnt
      always_ff @(posedge clk) begin
        if (rst)
          row_addr <= '0;
        else if ((state == ST_ACT) && (cnt == '0))
          row_addr <= row_addr + 1'b1;
      end
      AST_CAS_QUIET: assert property (@(posedge clk) disable iff (rst)
        cas_n); // R10
      AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
        (row_addr != $past(row_addr)) |-> (row_addr == $past(row_addr) + 1'b1)); // R10
    end else begin : g_cbr
      assign row_addr = '0;
      AST_CAS_FIRST: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> $past(!cas_n)); // R4
    end
  endgenerate

  AST_RAS_IN_REQ: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> ref_req); // R5
  AST_START_GRANTED: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_SETUP) && ($past(state) == ST_IDLE)) |-> $past(ref_gnt)); // R6
endmodule

// File: rtl/dref_sched.sv
module dref_sched #(
  parameter int CLK_KHZ      = 125000,
  parameter int PAUSE_US     = 200,
  parameter int RETAIN_MS    = 16,
  parameter int ROWS         = 1024,
  parameter int PAUSE_CYC    = CLK_KHZ * PAUSE_US / 1000,
  parameter int INTERVAL_CYC = CLK_KHZ * RETAIN_MS / ROWS,
  parameter int WAKE_CYCLES  = 8,
  parameter int MAX_PEND     = 4,
  parameter int SETUP_CYC    = 2,
  parameter int RAS_LOW_CYC  = 4,
  parameter int PRECHG_CYC   = 3,
  parameter int LATE_W       = 8,
  parameter bit RAS_ONLY     = 1'b0,
  localparam int ROW_W       = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_gnt,
  output logic              ref_req,
  output logic              ras_n,
  output logic              cas_n,
  output logic [ROW_W-1:0]  row_addr,
  output logic              init_done,
  output logic [LATE_W-1:0] late_cnt
);
  logic run, pause_end, tick, want, start, done;

  dref_ticker #(
    .PAUSE_CYC   (PAUSE_CYC),
    .INTERVAL_CYC(INTERVAL_CYC)
  ) u_ticker (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .pause_end(pause_end),
    .tick     (tick)
  );

  dref_budget #(
    .WAKE_CYCLES(WAKE_CYCLES),
    .MAX_PEND   (MAX_PEND),
    .LATE_W     (LATE_W)
  ) u_budget (
    .clk      (clk),
    .rst      (rst),
    .pause_end(pause_end),
    .tick     (tick),
    .start    (start),
    .done     (done),
    .want     (want),
    .init_done(init_done),
    .late_cnt (late_cnt)
  );

  dref_strobe #(
    .SETUP_CYC  (SETUP_CYC),
    .RAS_LOW_CYC(RAS_LOW_CYC),
    .PRECHG_CYC (PRECHG_CYC),
    .ROW_W      (ROW_W),
    .RAS_ONLY   (RAS_ONLY)
  ) u_strobe (
    .clk     (clk),
    .rst     (rst),
    .want    (want),
    .ref_gnt (ref_gnt),
    .ref_req (ref_req),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .row_addr(row_addr),
    .start   (start),
    .done    (done)
  );

  AST_NO_REQ_IN_PAUSE: assert property (@(posedge clk) disable iff (rst)
    !run |-> !ref_req); // R2
  AST_NO_INIT_IN_PAUSE: assert property (@(posedge clk) disable iff (rst)
    !run |-> !init_done); // R3
endmodule

// File: tb/test_dref_sched.sv
module test_dref_sched;
  localparam int PAUSE  = 250;
  localparam int IVL    = 100;
  localparam int RO_IVL = 50;
  localparam int SETUP  = 2;
  localparam int RASLO  = 4;
  localparam int PRECH  = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       gnt = 1'b0, ro_gnt = 1'b0;
  logic       auto_gnt = 1'b1;
  logic       ref_req, ras_n, cas_n, init_done;
  logic       ro_req, ro_ras_n, ro_cas_n, ro_init;
  logic [9:0] row_addr, ro_row;
  logic [7:0] late_cnt, ro_late;

  int n_tests = 0, n_fail = 0;
  int pulses = 0, ro_pulses = 0, ro_bad = 0, ro_exp = 0;
  bit ro_wrap_ok = 1'b0;

  always #4 clk = ~clk;

  dref_sched #(.PAUSE_CYC(PAUSE), .INTERVAL_CYC(IVL)) i_dref_sched (
    .clk(clk), .rst(rst), .ref_gnt(gnt), .ref_req(ref_req), .ras_n(ras_n),
    .cas_n(cas_n), .row_addr(row_addr), .init_done(init_done), .late_cnt(late_cnt));

  dref_sched #(.PAUSE_CYC(PAUSE), .INTERVAL_CYC(RO_IVL), .RAS_ONLY(1'b1)) i_dref_sched_ro (
    .clk(clk), .rst(rst), .ref_gnt(ro_gnt), .ref_req(ro_req), .ras_n(ro_ras_n),
    .cas_n(ro_cas_n), .row_addr(ro_row), .init_done(ro_init), .late_cnt(ro_late));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // grant responders
  initial forever begin
    @(negedge clk);
    gnt    = auto_gnt && ref_req;
    ro_gnt = ro_req;
  end

  // strobe monitor, main instance: R4, R5
  initial begin
    automatic bit p_ras = 1'b1, p_req = 1'b0;
    automatic int ras_run = 0, hi_run = 0, cas_lead = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (p_ras && !ras_n) begin
          chk(!cas_n, "R4 cas low at ras fall", cas_n, 0);
          chk(cas_lead == SETUP, "R4 cas lead cycles", cas_lead, SETUP);
        end
        if (!p_ras && ras_n) begin
          chk(ras_run == RASLO, "R5 ras low cycles", ras_run, RASLO);
          pulses++;
        end
        if (p_req && !ref_req)
          chk(hi_run == PRECH, "R5 precharge cycles", hi_run, PRECH);
        ras_run  = ras_n ? 0 : ras_run + 1;
        hi_run   = ras_n ? hi_run + 1 : 0;
        cas_lead = (!cas_n && ras_n) ? cas_lead + 1 : 0;
        p_ras    = ras_n;
        p_req    = ref_req;
      end
    end
  end

  // row-only instance monitor: R10
  initial begin
    automatic bit p_ras = 1'b1;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (!ro_cas_n) ro_bad++;
        if (p_ras && !ro_ras_n) begin
          if (int'(ro_row) != ro_exp) ro_bad++;
          if (ro_exp == 0 && ro_pulses > 0) begin
            chk(ro_row == 10'd0, "R10 row wrap 1023->0", ro_row, 0);
            ro_wrap_ok = 1'b1;
          end
          ro_exp = (ro_exp + 1) % 1024;
        end
        if (!p_ras && ro_ras_n) ro_pulses++;
        p_ras = ro_ras_n;
      end
    end
  end

  task automatic wait_req_fall;
    automatic bit p = 1'b0;
    forever begin
      @(negedge clk);
      if (p && !ref_req) break;
      p = ref_req;
    end
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    chk(ras_n && cas_n, "R1 strobes high in reset", {ras_n, cas_n}, 3);
    chk(!ref_req && !init_done, "R1 req/init low in reset", {ref_req, init_done}, 0);
    chk(late_cnt == 0, "R1 late count zero", late_cnt, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ras_n && cas_n && !ref_req && !init_done, "R1 idle after reset",
        {ras_n, cas_n, ref_req, init_done}, 12);
  endtask

  task automatic t_pause_wake;
    automatic int early = 0, waited = 0, p0;
    for (int k = 1; k < PAUSE; k++) begin
      if (ref_req) early++;
      @(negedge clk);
    end
    chk(early == 0, "R2 no request during pause", early, 0);
    p0 = pulses;
    while (!ref_req && waited < 10) begin
      @(negedge clk);
      waited++;
    end
    chk(ref_req, "R2 request after pause", waited, 3);
    waited = 0;
    while (!init_done && waited < 600) begin
      @(negedge clk);
      waited++;
    end
    chk(init_done, "R3 init done reached", init_done, 1);
    chk(pulses - p0 == 8, "R3 wake burst length", pulses - p0, 8);
  endtask

  task automatic t_period;
    automatic int p0, l0;
    repeat (50) @(negedge clk);
    p0 = pulses;
    l0 = late_cnt;
    repeat (10 * IVL) @(negedge clk);
    chk((pulses - p0) >= 9 && (pulses - p0) <= 11, "R7 refresh cadence", pulses - p0, 10);
    chk(late_cnt == l0, "R7 no late under prompt grant", late_cnt, l0);
  endtask

  task automatic t_late;
    automatic int p0, l0, busy = 0;
    wait_req_fall();
    auto_gnt = 1'b0;
    repeat (250) begin
      @(negedge clk);
      if (!ras_n || !cas_n) busy++;
    end
    chk(busy == 0, "R6 strobes idle without grant", busy, 0);
    chk(ref_req, "R6 request held without grant", ref_req, 1);
    p0 = pulses;
    l0 = late_cnt;
    auto_gnt = 1'b1;
    repeat (35) @(negedge clk);
    chk(pulses - p0 == 2, "R8 queued refreshes served", pulses - p0, 2);
    chk(late_cnt - l0 == 1, "R8 one late refresh", late_cnt - l0, 1);
  endtask

  task automatic t_miss;
    automatic int p0, waited = 0;
    wait_req_fall();
    auto_gnt = 1'b0;
    repeat (450) @(negedge clk);
    chk(init_done, "R9 init held at queue limit", init_done, 1);
    repeat (100) @(negedge clk);
    chk(!init_done, "R9 init dropped on overflow", init_done, 0);
    p0 = pulses;
    auto_gnt = 1'b1;
    while (!init_done && waited < 400) begin
      @(negedge clk);
      waited++;
    end
    chk(init_done, "R9 init regained", init_done, 1);
    chk(pulses - p0 == 8, "R9 rewake burst length", pulses - p0, 8);
  endtask

  task automatic t_rasonly;
    while (ro_pulses < 1030) @(negedge clk);
    chk(ro_wrap_ok, "R10 wrap observed", ro_wrap_ok, 1);
    chk(ro_bad == 0, "R10 row sequence and cas idle", ro_bad, 0);
  endtask

  initial begin
    t_reset();
    t_pause_wake();
    t_period();
    t_late();
    t_miss();
    t_rasonly();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end
endmodule